// File: doc/BRIEF.md
# SMBus Alert Response Responder

This block lets a device raise an interrupt on a shared, active-low, open-drain alert line and then identify itself to the host. When the host starts a read to the shared alert response address, a device whose alert is pending acknowledges. It then returns its own 7-bit address as the data byte. Several devices can answer the same read. They resolve the contention bit by bit on the wired-AND data line, and the device with the numerically lowest address wins.

A device that loses keeps its alert asserted, so it can try again on a later alert response read. A device that wins stays pending until two things have happened: the host has read its status, and the internal condition that caused the alert has gone away. The block only watches the clock and data lines and pulls them low. A separate slave interface on the same lines handles ordinary register traffic and reports status reads through a one-cycle strobe.

Both bus inputs are resynchronised inside the block. The system clock must run at least about ten times faster than the bus clock, because start, stop and clock edges are recovered by oversampling.

Top module: `smba_responder`

## Requirements
- R1: After reset neither line is pulled. `alert_pull` is 1 on the cycle after `alert_cond` is sampled high, and stays 1 while the alert is pending.
- R2: The bus address byte is a 7-bit address sent MSB first, followed by a read/write bit where 1 means read. The alert response address is 0001100, so the read form of the byte is 0x19. When that byte arrives while an alert is pending, the block acknowledges by pulling SDA low for the ninth clock.
- R3: The byte returned after the acknowledge is `own_addr` in bits 7:1 with bit 0 equal to 0, sent MSB first. A 0 bit is sent by pulling SDA low and a 1 bit by leaving it released.
- R4: With no alert pending, a read to the alert response address is not acknowledged.
- R5: The block never drives SDA for any other address byte. This includes the device's own address with the read bit, and the alert response address with the write bit.
- R6: The alert is released only when all three of these hold: the device has answered an alert response read to completion, a `status_rd` strobe has arrived after that answer, and `alert_cond` is low. A status strobe that arrives before the answer is ignored.
- R7: While sending its address, the block checks SDA on each clock rise where it left SDA released to send a 1. If SDA is low there, the block stops driving SDA for the rest of the byte. That answer then does not count toward release, and the alert stays asserted.
- R8: Against a contender with a higher address, the host reads the block's own address byte intact.
- R9: If `own_addr` equals the alert response address, the block never acknowledges it.
- R10: A STOP condition releases SDA on the cycle after it is detected. An answer cut short by a STOP does not count toward release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sensed level of the bus clock line |
| sda_i | input | 1 | Sensed level of the bus data line |
| own_addr | input | 7 | Device's own bus address, held static |
| alert_cond | input | 1 | Internal alert condition, active high |
| status_rd | input | 1 | One-cycle strobe: host has read the status registers |
| sda_pull | output | 1 | 1 pulls the data line low |
| alert_pull | output | 1 | 1 pulls the alert line low |

## Verification
A corrupted bit counter or transmit shift register shows up on SDA within one bus bit time, as a wrong bit in the returned address or a missing or misplaced acknowledge. A wrong arbitration flag shows up as a 0 forced onto SDA where a lower-addressed contender sent its address. It also shows up later, as an alert that releases after a lost round. Errors in the release bookkeeping are only visible on `alert_pull`, a few system cycles after the status strobe or the fall of the condition. The directed tests therefore check that line after each of those events on its own.

// File: rtl/smba_pkg.sv
// Shared constants and types for the alert response responder.
// Assumes a 7-bit bus address and an 8-bit byte on the wire.
package smba_pkg;
    localparam int ADDR_W    = 7;
    localparam int BYTE_BITS = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] ARA_DEFAULT = 7'b0001100;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_DATA,
        ST_MACK,
        ST_SKIP
    } xfer_state_t;
endpackage

// File: rtl/smba_bus_edges.sv
// Resynchronises the bus lines and recovers clock edges, START and STOP.
// Assumes the system clock oversamples SCL by a wide margin; the idle bus
// level (both lines high) is the reset value so no false edge follows reset.
module smba_bus_edges #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_sr, sda_sr;
    logic scl_s, scl_d, sda_d;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            // Purpose: single-stage capture of both lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= scl_i;
                    sda_sr <= sda_i;
                end
            end
        end else begin : g_chain
            // Purpose: multi-stage synchroniser chain for both lines.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_sr <= '1;
                    sda_sr <= '1;
                end else begin
                    scl_sr <= {scl_sr[SYNC_STAGES-2:0], scl_i};
                    sda_sr <= {sda_sr[SYNC_STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    assign scl_s = scl_sr[SYNC_STAGES-1];
    assign sda_s = sda_sr[SYNC_STAGES-1];

    // Purpose: one-cycle history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    // Purpose: decode clock edges and the two bus conditions.
    always_comb begin
        scl_rise  = scl_s & ~scl_d;
        scl_fall  = ~scl_s & scl_d;
        start_det = scl_s & scl_d & sda_d & ~sda_s;
        stop_det  = scl_s & scl_d & ~sda_d & sda_s;
    end
endmodule

// File: rtl/smba_xfer.sv
// Bus-side engine: matches the alert response read, acknowledges it, then
// sends the device address MSB first with wired-AND arbitration.
// Assumes own_addr is static while a transfer is in flight.
module smba_xfer
    import smba_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARA = ARA_DEFAULT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              alert_pend,
    output logic              sda_drv,
    output logic              arb_lost,
    output logic              ara_won
);
    localparam int CNT_W = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_BITS);

    xfer_state_t          state;
    logic [CNT_W-1:0]     bit_cnt;
    logic [BYTE_BITS-1:0] rx_sr, tx_sr;
    logic                 hit;

    // Purpose: decide whether the received byte calls on this device.
    assign hit = (rx_sr == {ARA, 1'b1}) && alert_pend && (own_addr != ARA);

    // Purpose: transfer sequencing, acknowledge and arbitrated transmit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            rx_sr    <= '0;
            tx_sr    <= '0;
            sda_drv  <= 1'b0;
            arb_lost <= 1'b0;
            ara_won  <= 1'b0;
        end else begin
            ara_won <= 1'b0;
            if (start_det) begin
                state    <= ST_ADDR;
                bit_cnt  <= '0;
                sda_drv  <= 1'b0;
                arb_lost <= 1'b0;
            end else if (stop_det) begin
                state   <= ST_IDLE;
                sda_drv <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_sr   <= {rx_sr[BYTE_BITS-2:0], sda_s};
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall && bit_cnt == LAST) begin
                            if (hit) begin
                                state   <= ST_ACK;
                                sda_drv <= 1'b1;
                            end else begin
                                state <= ST_SKIP;
                            end
                        end
                    end
                    ST_ACK: begin
                        if (scl_fall) begin
                            state    <= ST_DATA;
                            bit_cnt  <= '0;
                            tx_sr    <= {own_addr[ADDR_W-2:0], 2'b00};
                            sda_drv  <= ~own_addr[ADDR_W-1];
                            arb_lost <= 1'b0;
                        end
                    end
                    ST_DATA: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                            if (!sda_drv && !sda_s)
                                arb_lost <= 1'b1;
                        end else if (scl_fall) begin
                            if (bit_cnt == LAST) begin
                                state   <= ST_MACK;
                                sda_drv <= 1'b0;
                            end else begin
                                sda_drv <= ~tx_sr[BYTE_BITS-1] && !arb_lost;
                                tx_sr   <= {tx_sr[BYTE_BITS-2:0], 1'b0};
                            end
                        end
                    end
                    ST_MACK: begin
                        if (scl_fall) begin
                            state   <= ST_SKIP;
                            ara_won <= !arb_lost;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/smba_alert_ctl.sv
// Alert bookkeeping: raises the pending alert from the condition and
// releases it only after a won answer, a later status read and a quiet
// condition. Assumes status_rd is a one-cycle strobe.
module smba_alert_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic alert_cond,
    input  logic status_rd,
    input  logic ara_won,
    output logic alert_pend,
    output logic answered
);
    logic rd_seen;

    // Purpose: pending / answered / status-seen state with joint release.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_pend <= 1'b0;
            answered   <= 1'b0;
            rd_seen    <= 1'b0;
        end else if (!alert_pend) begin
            alert_pend <= alert_cond;
            answered   <= 1'b0;
            rd_seen    <= 1'b0;
        end else if (answered && rd_seen && !alert_cond) begin
            alert_pend <= 1'b0;
            answered   <= 1'b0;
            rd_seen    <= 1'b0;
        end else begin
            if (ara_won)
                answered <= 1'b1;
            if (answered && status_rd)
                rd_seen <= 1'b1;
        end
    end
endmodule

// File: rtl/smba_responder.sv
// Top: alert line driver and alert response answerer on a shared bus.
// Assumes both bus lines are open drain; a 1 on a *_pull output pulls low.
module smba_responder
    import smba_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARA = ARA_DEFAULT,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              alert_cond,
    input  logic              status_rd,
    output logic              sda_pull,
    output logic              alert_pull
);
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic alert_pend, answered, arb_lost, ara_won, sda_drv;

    smba_bus_edges #(.SYNC_STAGES(SYNC_STAGES)) u_edges (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    smba_xfer #(.ARA(ARA)) u_xfer (
        .clk(clk), .rst_n(rst_n), .sda_s(sda_s),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .own_addr(own_addr), .alert_pend(alert_pend),
        .sda_drv(sda_drv), .arb_lost(arb_lost), .ara_won(ara_won)
    );

    smba_alert_ctl u_alert (
        .clk(clk), .rst_n(rst_n), .alert_cond(alert_cond),
        .status_rd(status_rd), .ara_won(ara_won),
        .alert_pend(alert_pend), .answered(answered)
    );

    assign sda_pull   = sda_drv;
    assign alert_pull = alert_pend;
endmodule

// File: rtl/smba_responder_chk.sv
// Property checker for smba_responder, attached by bind below.
// Assumes own_addr changes only while the bus is idle.
module smba_responder_chk
    import smba_pkg::*;
#(
    parameter logic [ADDR_W-1:0] ARA = ARA_DEFAULT
) (
    input logic              clk,
    input logic              rst_n,
    input logic              alert_cond,
    input logic              alert_pull,
    input logic              sda_pull,
    input logic [ADDR_W-1:0] own_addr,
    input logic              stop_det,
    input logic              arb_lost,
    input logic              answered
);
    // R1: a sampled condition always leaves the alert line pulled next cycle.
    a_r1_cond_raises_alert: assert property (@(posedge clk) disable iff (!rst_n)
        alert_cond |=> alert_pull);

    // R6: a release needs a completed answer and a quiet condition.
    a_r6_release_needs_answer: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(alert_pull) |-> ($past(answered) && !$past(alert_cond)));

    // R7: once arbitration is lost the data line is left alone.
    a_r7_loser_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
        arb_lost |-> !sda_pull);

    // R9: an own address equal to the shared address never drives the bus.
    a_r9_no_self_clash: assert property (@(posedge clk) disable iff (!rst_n)
        (own_addr == ARA) |-> !sda_pull);

    // R10: a STOP leaves the data line released on the following cycle.
    a_r10_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        $past(stop_det) |-> !sda_pull);
endmodule

bind smba_responder smba_responder_chk #(.ARA(ARA)) u_chk (
    .clk(clk), .rst_n(rst_n), .alert_cond(alert_cond),
    .alert_pull(alert_pull), .sda_pull(sda_pull), .own_addr(own_addr),
    .stop_det(stop_det), .arb_lost(arb_lost), .answered(answered)
);

// File: tb/tb_smba_responder.sv
// Directed bench: the bench acts as host and as an optional rival device.
module tb_smba_responder;
    localparam logic [6:0] ARA_ADDR = 7'b0001100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_h = 1'b1;
    logic       rival_pull = 1'b0;
    logic [6:0] own_addr = 7'h2A;
    logic       alert_cond = 1'b0;
    logic       status_rd = 1'b0;
    logic       sda_pull, alert_pull;
    logic       sda_bus;

    logic       rival_on = 1'b0;
    logic [7:0] rival_byte = 8'hFF;
    int         n_checks = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    assign sda_bus = sda_h & ~sda_pull & ~rival_pull;

    smba_responder dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .own_addr(own_addr), .alert_cond(alert_cond), .status_rd(status_rd),
        .sda_pull(sda_pull), .alert_pull(alert_pull)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        alert_cond = 1'b0; status_rd = 1'b0; rival_on = 1'b0; rival_pull = 1'b0;
        scl = 1'b1; sda_h = 1'b1;
        rst_n = 1'b0; tick(4); rst_n = 1'b1; tick(4);
    endtask

    task automatic strobe_status();
        status_rd = 1'b1; tick(1); status_rd = 1'b0; tick(4);
    endtask

    task automatic bus_start();
        sda_h = 1'b1; scl = 1'b1; tick(6);
        sda_h = 1'b0; tick(6);
        scl = 1'b0; tick(6);
    endtask

    task automatic bus_stop();
        sda_h = 1'b0; tick(6);
        scl = 1'b1; tick(6);
        sda_h = 1'b1; tick(6);
    endtask

    task automatic bus_bit(input logic b, output logic r);
        sda_h = b; tick(6);
        scl = 1'b1; tick(3);
        r = sda_bus; tick(3);
        scl = 1'b0; tick(6);
    endtask

    task automatic send_addr(input logic [7:0] byte_v, output bit ack);
        logic r;
        bus_start();
        for (int i = 7; i >= 0; i--) bus_bit(byte_v[i], r);
        bus_bit(1'b1, r);
        ack = !r;
    endtask

    // Host reads a byte while the bench rival contends with rival_byte.
    task automatic read_byte(output logic [7:0] d);
        logic r;
        bit   rlost = 1'b0;
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            rival_pull = rival_on && !rlost && !rival_byte[i];
            bus_bit(1'b1, r);
            if (rival_on && !rlost && rival_byte[i] && !r) rlost = 1'b1;
            d = {d[6:0], r};
        end
        rival_pull = 1'b0;
    endtask

    task automatic ara_read(output bit ack, output logic [7:0] d);
        logic r;
        send_addr({ARA_ADDR, 1'b1}, ack);
        d = 8'h00;
        if (ack || rival_on) begin
            read_byte(d);
            bus_bit(1'b1, r);
        end
        bus_stop();
    endtask

    task automatic t_reset();
        do_reset();
        check(alert_pull == 1'b0, "R1 reset alert", int'(alert_pull), 0);
        check(sda_pull == 1'b0, "R1 reset sda", int'(sda_pull), 0);
    endtask

    task automatic t_raise();
        do_reset();
        alert_cond = 1'b1; tick(4);
        check(alert_pull == 1'b1, "R1 alert raised", int'(alert_pull), 1);
    endtask

    task automatic t_answer();
        bit ack; logic [7:0] d;
        do_reset(); own_addr = 7'h2A; alert_cond = 1'b1; tick(4);
        ara_read(ack, d);
        check(ack, "R2 ack to ARA", int'(ack), 1);
        check(d == 8'h54, "R3 returned byte", int'(d), 'h54);
        own_addr = 7'h71; do_reset(); alert_cond = 1'b1; tick(4);
        ara_read(ack, d);
        check(d == 8'hE2, "R3 returned byte alt", int'(d), 'hE2);
        own_addr = 7'h2A;
    endtask

    task automatic t_no_alert();
        bit ack; logic [7:0] d;
        do_reset();
        ara_read(ack, d);
        check(!ack, "R4 no ack without alert", int'(ack), 0);
    endtask

    task automatic t_other_addr();
        bit ack;
        do_reset(); alert_cond = 1'b1; tick(4);
        send_addr({own_addr, 1'b1}, ack); bus_stop();
        check(!ack, "R5 own address ignored", int'(ack), 0);
        send_addr({ARA_ADDR, 1'b0}, ack); bus_stop();
        check(!ack, "R5 ARA write ignored", int'(ack), 0);
    endtask

    task automatic t_clear();
        bit ack; logic [7:0] d;
        do_reset(); alert_cond = 1'b1; tick(4);
        strobe_status(); alert_cond = 1'b0; tick(4);
        check(alert_pull, "R6 early status read ignored", int'(alert_pull), 1);
        alert_cond = 1'b1;
        ara_read(ack, d);
        strobe_status();
        check(alert_pull, "R6 held while condition stays", int'(alert_pull), 1);
        alert_cond = 1'b0; tick(4);
        check(!alert_pull, "R6 released", int'(alert_pull), 0);
        do_reset(); alert_cond = 1'b1; tick(4);
        ara_read(ack, d); alert_cond = 1'b0; tick(6);
        check(alert_pull, "R6 held without status read", int'(alert_pull), 1);
        strobe_status();
        check(!alert_pull, "R6 released after read", int'(alert_pull), 0);
    endtask

    task automatic t_lose();
        bit ack; logic [7:0] d;
        do_reset(); own_addr = 7'h2A; alert_cond = 1'b1; tick(4);
        rival_on = 1'b1; rival_byte = {7'h10, 1'b0};
        ara_read(ack, d);
        check(d == 8'h20, "R7 lower rival wins", int'(d), 'h20);
        alert_cond = 1'b0; strobe_status();
        check(alert_pull, "R7 loser keeps alert", int'(alert_pull), 1);
        rival_on = 1'b0;
        ara_read(ack, d);
        check(d == 8'h54, "R7 retry wins", int'(d), 'h54);
        strobe_status();
        check(!alert_pull, "R7 released after retry", int'(alert_pull), 0);
    endtask

    task automatic t_win();
        bit ack; logic [7:0] d;
        do_reset(); own_addr = 7'h2A; alert_cond = 1'b1; tick(4);
        rival_on = 1'b1; rival_byte = {7'h50, 1'b0};
        ara_read(ack, d);
        rival_on = 1'b0;
        check(d == 8'h54, "R8 beats higher rival", int'(d), 'h54);
    endtask

    task automatic t_self_clash();
        bit ack; logic [7:0] d;
        do_reset(); own_addr = ARA_ADDR; alert_cond = 1'b1; tick(4);
        ara_read(ack, d);
        check(!ack, "R9 no ack when own equals ARA", int'(ack), 0);
        own_addr = 7'h2A;
    endtask

    task automatic t_abort();
        bit ack; logic r;
        do_reset(); own_addr = 7'h2A; alert_cond = 1'b1; tick(4);
        send_addr({ARA_ADDR, 1'b1}, ack);
        bus_bit(1'b1, r);
        bus_stop();
        check(!sda_pull && sda_bus, "R10 STOP releases SDA", int'(sda_pull), 0);
        alert_cond = 1'b0; strobe_status();
        check(alert_pull, "R10 cut answer not counted", int'(alert_pull), 1);
    endtask

    initial begin
        t_reset();
        t_raise();
        t_answer();
        t_no_alert();
        t_other_addr();
        t_clear();
        t_lose();
        t_win();
        t_self_clash();
        t_abort();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule